// File: doc/BRIEF.md
# Multicycle Controller-Datapath Processor Core

This block is a compact 16-bit processor. A state machine drives a datapath built from a program counter, an instruction register, a sixteen-entry register file with two read ports, and one ALU. The core uses a single memory for both instructions and data. It drives an address bus, a write-data bus, and separate read and write strobes, and it takes read data back on a bus of its own.

Every instruction uses three clock cycles. In the first cycle the core fetches the word at the program counter and increments the counter. In the second it decodes the opcode. In the third it runs the execute state for that opcode and then returns to fetch. Memory read data must be valid in the same cycle as the address, so every state lasts exactly one clock.

Each instruction word has four fields. Bits 15:12 hold the opcode and bits 11:8 hold register `rn`. Bits 7:4 hold register `rm`, and bits 7:0 also hold an 8-bit direct address, immediate value or jump target. The 8-bit field is always zero-extended before use. Seven opcodes are defined. Any other opcode parks the core in a halted state until reset.

Top module: `fsmd_cpu_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core clears the program counter to 0 and enters the fetch state. After reset, `mem_addr` is 0, `mem_rd` is 1, `mem_wr` is 0 and `halted` is 0.
- R2: Each instruction takes exactly three cycles: fetch, then decode, then one execute state. Fetch reads M[PC] into the instruction register with `mem_rd` high and adds 1 to the PC.
- R3: Opcode 0000 loads RF[rn] from M[zero-extended bits 7:0].
- R4: Opcode 0001 writes RF[rn] to M[zero-extended bits 7:0].
- R5: Opcode 0010 writes RF[rm] to the memory word whose address is held in RF[rn].
- R6: Opcode 0011 loads the zero-extended bits 7:0 into RF[rn].
- R7: Opcode 0100 sets RF[rn] = RF[rn] + RF[rm], and opcode 0101 sets RF[rn] = RF[rn] - RF[rm]. Both wrap modulo 2^16.
- R8: Opcode 0110 loads the PC with zero-extended bits 7:0 when RF[rn] is 0. Otherwise the PC keeps its value and execution falls through to the next word.
- R9: Opcodes 0111 through 1111 move the core, right after decode, into a state where `halted` is 1 and `mem_rd` and `mem_wr` are both 0. The core stays there until reset.
- R10: `mem_rd` and `mem_wr` are never high together. `mem_wr` rises only in the execute cycle of opcodes 0001 and 0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory word address |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle as the address |
| mem_wdata | output | 16 | Memory write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe, taken at the next rising edge |
| halted | output | 1 | High once an undefined opcode has been decoded |

## Verification
A register or memory result becomes visible at the clock edge that ends the instruction's execute cycle. That edge is the third edge after the instruction's fetch began, so instruction k of a straight-line run completes after 3(k+1) edges counted from the first fetch. The bench counts edges from the release of reset and samples on the falling edge. It checks that `halted` is still low after 172 edges and high after 173, which is the count that the summing loop, the taken and not-taken jumps and the final decode predict. Memory contents are compared only after the core has halted, and a halt-only program must show `halted` on exactly the second edge.

// File: rtl/fsmd_cpu_pkg.sv
package fsmd_cpu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LDD = 4'd0,
    OP_STD = 4'd1,
    OP_STI = 4'd2,
    OP_LDI = 4'd3,
    OP_ADD = 4'd4,
    OP_SUB = 4'd5,
    OP_JZ  = 4'd6
  } opcode_e;

  typedef enum logic [3:0] {
    S_FETCH,
    S_DECODE,
    S_LDD,
    S_STD,
    S_STI,
    S_LDI,
    S_ADD,
    S_SUB,
    S_JZ,
    S_HALT
  } state_e;

  // register-file write source
  typedef enum logic [1:0] {
    WSRC_ALU = 2'b00,
    WSRC_MEM = 2'b01,
    WSRC_IMM = 2'b10
  } wsrc_e;

  // memory address source
  typedef enum logic [1:0] {
    ASRC_PC  = 2'b00,
    ASRC_DIR = 2'b01,
    ASRC_REG = 2'b10
  } asrc_e;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_SUB  = 2'b01,
    ALU_PASS = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic    ir_ld;
    logic    pc_inc;
    logic    pc_ld;
    logic    rf_we;
    wsrc_e   wsrc;
    asrc_e   asrc;
    alu_op_e alu_op;
    logic    wd_from_rm;
    logic    mem_rd;
    logic    mem_wr;
  } ctrl_t;

endpackage

// File: rtl/fsmd_cpu_regfile.sv
module fsmd_cpu_regfile #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  rsel_a,
  input  logic [SEL_W-1:0]  rsel_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);

  localparam int ENTRIES = 1 << SEL_W;

  logic [DATA_W-1:0] cells [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) cells[wsel] <= wdata;
  end

  assign rdata_a = cells[rsel_a];
  assign rdata_b = cells[rsel_b];

endmodule

// File: rtl/fsmd_cpu_alu.sv
module fsmd_cpu_alu
  import fsmd_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] res,
  output logic              zero
);

  always_comb begin
    unique case (op)
      ALU_ADD:  res = opa + opb;
      ALU_SUB:  res = opa - opb;
      default:  res = opa;
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/fsmd_cpu_ctrl.sv
module fsmd_cpu_ctrl
  import fsmd_cpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            alu_zero,
  output state_e          state,
  output ctrl_t           ctl
);

  state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        unique case (opcode)
          OP_LDD:  nxt = S_LDD;
          OP_STD:  nxt = S_STD;
          OP_STI:  nxt = S_STI;
          OP_LDI:  nxt = S_LDI;
          OP_ADD:  nxt = S_ADD;
          OP_SUB:  nxt = S_SUB;
          OP_JZ:   nxt = S_JZ;
          default: nxt = S_HALT;
        endcase
      end
      S_HALT:   nxt = S_HALT;
      default:  nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nxt;
  end

  always_comb begin
    ctl            = '0;
    ctl.wsrc       = WSRC_ALU;
    ctl.asrc       = ASRC_PC;
    ctl.alu_op     = ALU_PASS;
    unique case (state)
      S_FETCH: begin
        ctl.ir_ld  = 1'b1;
        ctl.pc_inc = 1'b1;
        ctl.mem_rd = 1'b1;
      end
      S_LDD: begin
        ctl.asrc   = ASRC_DIR;
        ctl.mem_rd = 1'b1;
        ctl.rf_we  = 1'b1;
        ctl.wsrc   = WSRC_MEM;
      end
      S_STD: begin
        ctl.asrc   = ASRC_DIR;
        ctl.mem_wr = 1'b1;
      end
      S_STI: begin
        ctl.asrc       = ASRC_REG;
        ctl.mem_wr     = 1'b1;
        ctl.wd_from_rm = 1'b1;
      end
      S_LDI: begin
        ctl.rf_we = 1'b1;
        ctl.wsrc  = WSRC_IMM;
      end
      S_ADD: begin
        ctl.rf_we  = 1'b1;
        ctl.alu_op = ALU_ADD;
      end
      S_SUB: begin
        ctl.rf_we  = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      S_JZ: begin
        ctl.alu_op = ALU_PASS;
        ctl.pc_ld  = alu_zero;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fsmd_cpu_core.sv
module fsmd_cpu_core
  import fsmd_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              halted
);

  localparam int OP_LSB  = DATA_W - OP_W;
  localparam int RN_LSB  = OP_LSB - SEL_W;
  localparam int RM_LSB  = RN_LSB - SEL_W;
  localparam int FLD_W   = RN_LSB;

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir;
  state_e            state;
  ctrl_t             ctl;

  logic [OP_W-1:0]   f_op;
  logic [SEL_W-1:0]  f_rn;
  logic [SEL_W-1:0]  f_rm;
  logic [FLD_W-1:0]  f_low;

  logic [DATA_W-1:0] rf_rd1;
  logic [DATA_W-1:0] rf_rd2;
  logic [DATA_W-1:0] rf_wd;
  logic [DATA_W-1:0] alu_y;
  logic              alu_z;

  assign f_op  = ir[DATA_W-1:OP_LSB];
  assign f_rn  = ir[OP_LSB-1:RN_LSB];
  assign f_rm  = ir[RN_LSB-1:RM_LSB];
  assign f_low = ir[FLD_W-1:0];

  fsmd_cpu_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .opcode   (f_op),
    .alu_zero (alu_z),
    .state    (state),
    .ctl      (ctl)
  );

  fsmd_cpu_regfile #(
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
  ) u_rf (
    .clk     (clk),
    .we      (ctl.rf_we),
    .wsel    (f_rn),
    .wdata   (rf_wd),
    .rsel_a  (f_rn),
    .rsel_b  (f_rm),
    .rdata_a (rf_rd1),
    .rdata_b (rf_rd2)
  );

  fsmd_cpu_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .opa  (rf_rd1),
    .opb  (rf_rd2),
    .op   (ctl.alu_op),
    .res  (alu_y),
    .zero (alu_z)
  );

  always_comb begin
    unique case (ctl.wsrc)
      WSRC_MEM: rf_wd = mem_rdata;
      WSRC_IMM: rf_wd = DATA_W'(f_low);
      default:  rf_wd = alu_y;
    endcase
  end

  always_comb begin
    unique case (ctl.asrc)
      ASRC_DIR: mem_addr = ADDR_W'(f_low);
      ASRC_REG: mem_addr = ADDR_W'(rf_rd1);
      default:  mem_addr = pc;
    endcase
  end

  assign mem_wdata = ctl.wd_from_rm ? rf_rd2 : rf_rd1;
  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;
  assign halted    = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ir <= '0;
    end else begin
      if (ctl.ir_ld)       ir <= mem_rdata;
      if (ctl.pc_ld)       pc <= ADDR_W'(f_low);
      else if (ctl.pc_inc) pc <= pc + 1'b1;
    end
  end

endmodule

// File: rtl/fsmd_cpu_checker.sv
module fsmd_cpu_checker
  import fsmd_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input state_e            state,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] rf_rd1,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              halted
);

  assert_reset_entry_R1: assert property (@(posedge clk)
    rst |=> (pc == '0 && state == S_FETCH));

  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |=> (state == S_DECODE && pc == $past(pc) + 1'b1));

  assert_decode_dispatch_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_DECODE) |=> (state != S_FETCH && state != S_DECODE));

  assert_exec_return_R2: assert property (@(posedge clk) disable iff (rst)
    (state != S_FETCH && state != S_DECODE && state != S_HALT) |=> (state == S_FETCH));

  assert_jz_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (state == S_JZ && rf_rd1 != '0) |=> (pc == $past(pc)));

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd && !mem_wr));

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_write_state_R10: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (state == S_STD || state == S_STI));

endmodule

bind fsmd_cpu_core fsmd_cpu_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .state  (state),
  .pc     (pc),
  .rf_rd1 (rf_rd1),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .halted (halted)
);

// File: tb/sim_fsmd_cpu_core.sv
module sim_fsmd_cpu_core;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 256;
  localparam int PROG_LEN   = 21;
  localparam int N_EXP      = 6;

  // R3..R8: sum 10..1 with a jump-always loop through zero register R3
  localparam logic [15:0] PROG [PROG_LEN] = '{
    16'h3000, // 0  LDI R0,0          R6
    16'h310A, // 1  LDI R1,10
    16'h3201, // 2  LDI R2,1
    16'h3300, // 3  LDI R3,0
    16'h6108, // 4  JZ  R1,8          R8 taken at the end
    16'h4010, // 5  ADD R0,R1         R7
    16'h5120, // 6  SUB R1,R2         R7
    16'h6304, // 7  JZ  R3,4          R8 always taken
    16'h1080, // 8  STD 0x80,R0       R4
    16'h0480, // 9  LDD R4,0x80       R3
    16'h3590, // 10 LDI R5,0x90
    16'h2540, // 11 STI [R5],R4       R5
    16'h3600, // 12 LDI R6,0
    16'h5620, // 13 SUB R6,R2 -> FFFF R7
    16'h1691, // 14 STD 0x91,R6
    16'h4620, // 15 ADD R6,R2 -> 0000 R7
    16'h1692, // 16 STD 0x92,R6
    16'h37FF, // 17 LDI R7,0xFF       R6 zero-extend
    16'h1793, // 18 STD 0x93,R7
    16'h6200, // 19 JZ R2,0 not taken R8
    16'hF000  // 20 undefined opcode  R9
  };

  localparam logic [7:0]  EXP_ADDR [N_EXP] = '{8'h80, 8'h90, 8'h91, 8'h92, 8'h93, 8'h94};
  localparam logic [15:0] EXP_DATA [N_EXP] = '{16'd55, 16'd55, 16'hFFFF, 16'h0000, 16'h00FF, 16'h0000};
  localparam string       EXP_REQ  [N_EXP] = '{"R4", "R5", "R7", "R7", "R6", "R10"};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] mem_wdata;
  logic        mem_rd;
  logic        mem_wr;
  logic        halted;

  logic [15:0] mem [MEM_WORDS];
  int          n_writes = 0;
  int          n_halt_access = 0;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsmd_cpu_core u0 (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .halted    (halted)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      n_writes <= n_writes + 1;
    end
    if (halted && (mem_rd || mem_wr)) n_halt_access <= n_halt_access + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w0;
    int h0;

    // ---- run 1: summing program ----
    clear_mem();
    for (int i = 0; i < PROG_LEN; i++) mem[i] = PROG[i];
    do_reset();
    // R1: state while reset held, sampled after reset edges
    check(mem_addr == 16'h0, "R1 addr", 32'(mem_addr), 32'h0);
    check(mem_rd == 1'b1 && mem_wr == 1'b0, "R1 strobes", {30'b0, mem_rd, mem_wr}, 32'h2);
    check(halted == 1'b0, "R1 halted", 32'(halted), 32'h0);

    rst = 1'b0;
    w0 = n_writes;
    h0 = n_halt_access;
    // R2/R8/R9: 57 instructions x 3 cycles, then fetch+decode of F000
    for (int c = 0; c < 172; c++) begin
      @(posedge clk);
      @(negedge clk);
    end
    check(halted == 1'b0, "R2 halt not before edge 173", 32'(halted), 32'h0);
    @(posedge clk);
    @(negedge clk);
    check(halted == 1'b1, "R9 halted at edge 173", 32'(halted), 32'h1);

    repeat (6) @(posedge clk);
    @(negedge clk);
    check(halted == 1'b1, "R9 halt sticky", 32'(halted), 32'h1);
    check(n_halt_access == h0, "R9 no access while halted", 32'(n_halt_access - h0), 32'h0);
    check(n_writes - w0 == 5, "R10 write count", 32'(n_writes - w0), 32'd5);

    for (int k = 0; k < N_EXP; k++)
      check(mem[EXP_ADDR[k]] == EXP_DATA[k], EXP_REQ[k], 32'(mem[EXP_ADDR[k]]), 32'(EXP_DATA[k]));

    // ---- run 2: halt on first word, lowest undefined opcode ----
    clear_mem();
    mem[0] = 16'h7000;
    mem[1] = 16'h1080;
    do_reset();
    rst = 1'b0;
    w0 = n_writes;
    @(posedge clk);
    @(negedge clk);
    check(halted == 1'b0 && mem_rd == 1'b0, "R2 decode cycle", {30'b0, halted, mem_rd}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check(halted == 1'b1, "R9 opcode 0111 halts", 32'(halted), 32'h1);
    check(mem_rd == 1'b0 && mem_wr == 1'b0, "R9 strobes low", {30'b0, mem_rd, mem_wr}, 32'h0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(n_writes == w0 && mem[8'h80] == 16'h0, "R9 next word not run", 32'(n_writes - w0), 32'h0);

    // ---- run 3: reset leaves halt and restarts at 0 ----
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(halted == 1'b0 && mem_addr == 16'h0, "R1 reset clears halt", {15'b0, halted, mem_addr}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule